// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter built from identical 4-bit stages. Each stage counts modulo 16, can be preset from a parallel data word, and produces a terminal-count flag. The top module chains a parameterised number of stages. The flag of each stage drives the trickle enable of the stage above it, so the chain behaves as one wide synchronous counter that advances on the rising clock edge.

Every stage receives the same clock, the same active-low clear, the same active-low load strobe and the same parallel count enable. The two count enables play different roles. Only the trickle enable feeds into the terminal-count flag, so the parallel enable can gate counting without lengthening the carry path between stages. A build-time parameter selects how the clear acts. It can be asynchronous, acting the moment it goes low, or synchronous, taking effect at the next rising edge.

The terminal-count output is a decoded combinational signal. Downstream logic may use it only as a synchronous enable, never as a clock or a reset.

Top module: `cnt_chain`

## Requirements
- R1: Each 4-bit stage counts upward in binary. A stage holding 15 (all ones) goes to 0 on its next count. The full chain holding all ones goes to all zeros on its next count.
- R2: At a rising edge, the actions rank as follows: clear first, then load, then count, then hold. With `clear_n` low and `load_n` low together, the result is zero.
- R3: With `ASYNC_CLR` = 1, a low `clear_n` forces `q` to zero at once, between clock edges, with no clock edge needed.
- R4: With `ASYNC_CLR` = 0, a low `clear_n` leaves `q` unchanged until the next rising edge, and clears it at that edge.
- R5: With `clear_n` high and `load_n` low, `q` takes the value of `din` at the next rising edge, whatever the values of `en_par` and `en_trk`. Stage k loads bits `din[4k+3:4k]`.
- R6: With `clear_n` high, `load_n` high, `en_par` high and `en_trk` high, `q` increments by one at each rising edge.
- R7: With `clear_n` and `load_n` high, `q` holds its value across a rising edge if `en_par` or `en_trk` is low.
- R8: `carry_out` is high exactly when `en_trk` is high and every bit of `q` is one. It follows `en_trk` combinationally and does not depend on `en_par`.
- R9: The terminal count of stage k drives the trickle enable of stage k+1. An upper stage therefore advances only in a cycle where every stage below it holds 15 and the chain is counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load strobe |
| en_par | input | 1 | Parallel count enable, shared by all stages |
| en_trk | input | 1 | Trickle count enable into the lowest stage |
| din | input | STAGES*W | Parallel preset data |
| q | output | STAGES*W | Counter state |
| carry_out | output | 1 | Terminal count of the top stage |

## Verification
The clocked properties assume that `clear_n`, `load_n`, `en_par`, `en_trk` and `din` change away from the rising clock edge. They also assume that an asynchronous clear is released well before an edge, so that the value sampled at each edge is unambiguous. The bench meets both assumptions by changing every input one nanosecond after a rising edge. For the mid-cycle clear it lowers `clear_n` at that point and samples the outputs one nanosecond later, before the next edge. Because the properties are disabled while `clear_n` is low, clear behaviour is checked only by properties that look at the cycle after the clear.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int unsigned STAGE_W = 4;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_STEP,
        ACT_KEEP
    } act_e;

    typedef struct packed {
        logic clear_n;
        logic load_n;
        logic en_par;
        logic en_trk;
    } ctl_t;

    // Fixed ranking: clear, load, step, keep.
    function automatic act_e pick_action(ctl_t c);
        if (!c.clear_n)                 return ACT_CLEAR;
        else if (!c.load_n)             return ACT_LOAD;
        else if (c.en_par && c.en_trk)  return ACT_STEP;
        else                            return ACT_KEEP;
    endfunction

endpackage

// File: rtl/cnt_decode.sv
module cnt_decode
    import cnt_pkg::*;
(
    input  ctl_t ctl,
    output act_e act
);

    always_comb begin
        act = pick_action(ctl);
    end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W         = STAGE_W,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_par,
    input  logic         en_trk,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    ctl_t         ctl;
    act_e         act;
    logic [W-1:0] q_nxt;

    assign ctl = '{clear_n: clear_n, load_n: load_n, en_par: en_par, en_trk: en_trk};

    cnt_decode u_dec (
        .ctl (ctl),
        .act (act)
    );

    always_comb begin
        unique case (act)
            ACT_CLEAR: q_nxt = '0;
            ACT_LOAD:  q_nxt = din;
            ACT_STEP:  q_nxt = q + ONE;
            default:   q_nxt = q;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) q <= '0;
                else          q <= q_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate

    // Terminal count: trickle enable and all ones only; parallel enable excluded.
    assign tc = en_trk & (q == TOP_VAL);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned W         = STAGE_W,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input  logic                  clk,
    input  logic                  clear_n,
    input  logic                  load_n,
    input  logic                  en_par,
    input  logic                  en_trk,
    input  logic [STAGES*W-1:0]   din,
    output logic [STAGES*W-1:0]   q,
    output logic                  carry_out
);

    localparam int unsigned TOTAL = STAGES * W;

    logic [STAGES:0] trk_link;

    assign trk_link[0] = en_trk;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            cnt_stage #(
                .W         (W),
                .ASYNC_CLR (ASYNC_CLR)
            ) u_stg (
                .clk     (clk),
                .clear_n (clear_n),
                .load_n  (load_n),
                .en_par  (en_par),
                .en_trk  (trk_link[g]),
                .din     (din[g*W +: W]),
                .q       (q[g*W +: W]),
                .tc      (trk_link[g+1])
            );
        end
    endgenerate

    assign carry_out = trk_link[STAGES];

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int unsigned STAGES    = 2,
    parameter int unsigned W         = 4,
    parameter bit          ASYNC_CLR = 1'b1
) (
    input logic                clk,
    input logic                clear_n,
    input logic                load_n,
    input logic                en_par,
    input logic                en_trk,
    input logic [STAGES*W-1:0] din,
    input logic [STAGES*W-1:0] q,
    input logic                carry_out
);

    localparam int unsigned        TOTAL = STAGES * W;
    localparam logic [TOTAL-1:0]   ONE   = {{(TOTAL-1){1'b0}}, 1'b1};

    // R2 R4
    clear_wins_chk: assert property (@(posedge clk)
        !clear_n |=> (q == '0));

    // R5
    load_copies_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (q == $past(din)));

    // R6 R1 R9
    count_steps_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_par && en_trk) |=> (q == $past(q) + ONE));

    // R7
    hold_still_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    // R8
    carry_needs_full_chk: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> (en_trk && (&q)));

    // R8
    carry_when_full_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (en_trk && (&q)) |-> carry_out);

endmodule

bind cnt_chain cnt_chain_chk #(
    .STAGES    (STAGES),
    .W         (W),
    .ASYNC_CLR (ASYNC_CLR)
) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/cnt_chain_bench.sv
`timescale 1ns/1ps
module cnt_chain_bench;

    localparam int unsigned STAGES = 2;
    localparam int unsigned W      = 4;
    localparam int unsigned TOTAL  = STAGES * W;

    logic             clk = 1'b0;
    logic             clear_n = 1'b0;
    logic             load_n = 1'b1;
    logic             en_par = 1'b0;
    logic             en_trk = 1'b0;
    logic [TOTAL-1:0] din = '0;
    logic [TOTAL-1:0] q_a, q_s;
    logic             co_a, co_s;

    logic [TOTAL-1:0] exp_q = '0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cnt_chain #(.STAGES(STAGES), .W(W), .ASYNC_CLR(1'b1)) u_cnt_chain (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .q(q_a), .carry_out(co_a)
    );

    cnt_chain #(.STAGES(STAGES), .W(W), .ASYNC_CLR(1'b0)) u_cnt_chain_sync (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .q(q_s), .carry_out(co_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference step taken from the requirements, applied at the next edge.
    task automatic cycle();
        logic [TOTAL-1:0] nxt;
        if (!clear_n)              nxt = '0;
        else if (!load_n)          nxt = din;
        else if (en_par && en_trk) nxt = exp_q + 1'b1;
        else                       nxt = exp_q;
        @(posedge clk);
        exp_q = nxt;
        #1;
    endtask

    task automatic both_q(input string req);
        chk(req, 32'(q_a), 32'(exp_q));
        chk(req, 32'(q_s), 32'(exp_q));
    endtask

    task automatic set(input logic c, input logic l, input logic p, input logic t);
        clear_n = c; load_n = l; en_par = p; en_trk = t;
    endtask

    task automatic t_reset();
        set(1'b0, 1'b1, 1'b0, 1'b0);
        cycle(); cycle();
        both_q("R2 reset state");
        chk("R8 reset carry", 32'(co_a), 32'h0);
    endtask

    task automatic t_load();
        din = 8'hA5; set(1'b1, 1'b0, 1'b0, 1'b0);
        cycle(); both_q("R5 load enables low");
        chk("R5 load value", 32'(q_a), 32'hA5);
        din = 8'h3C; set(1'b1, 1'b0, 1'b1, 1'b1);
        cycle(); chk("R5 load ignores enables", 32'(q_a), 32'h3C);
        chk("R2 load over count", 32'(q_s), 32'h3C);
    endtask

    task automatic t_count();
        set(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            cycle(); both_q("R6 count step");
        end
        chk("R6 count value", 32'(q_a), 32'h41);
    endtask

    task automatic t_hold();
        set(1'b1, 1'b1, 1'b0, 1'b1);
        cycle(); cycle(); chk("R7 hold par low", 32'(q_a), 32'h41);
        set(1'b1, 1'b1, 1'b1, 1'b0);
        cycle(); chk("R7 hold trk low", 32'(q_s), 32'h41);
    endtask

    task automatic t_wrap();
        din = 8'h0F; set(1'b1, 1'b0, 1'b0, 1'b0); cycle();
        set(1'b1, 1'b1, 1'b1, 1'b1); cycle();
        chk("R1 R9 stage wrap carries", 32'(q_a), 32'h10);
        din = 8'hFF; set(1'b1, 1'b0, 1'b0, 1'b0); cycle();
        set(1'b1, 1'b1, 1'b1, 1'b1); cycle();
        both_q("R1 full wrap");
        chk("R1 full wrap zero", 32'(q_a), 32'h00);
    endtask

    task automatic t_carry();
        din = 8'hFF; set(1'b1, 1'b0, 1'b0, 1'b0); cycle();
        set(1'b1, 1'b1, 1'b0, 1'b1); #1;
        chk("R8 carry with par low", 32'(co_a), 32'h1);
        en_trk = 1'b0; #1;
        chk("R8 carry follows trk low", 32'(co_a), 32'h0);
        en_trk = 1'b1; #0.5;
        chk("R8 carry follows trk high", 32'(co_s), 32'h1);
        din = 8'h2F; set(1'b1, 1'b0, 1'b0, 1'b0); cycle();
        set(1'b1, 1'b1, 1'b1, 1'b1); #1;
        chk("R9 no carry upper not full", 32'(co_a), 32'h0);
        en_trk = 1'b0; cycle();
        chk("R9 chain holds trk low", 32'(q_a), 32'h2F);
        en_trk = 1'b1; cycle();
        chk("R9 upper advances on lower tc", 32'(q_a), 32'h30);
    endtask

    task automatic t_prec();
        din = 8'h77; set(1'b0, 1'b0, 1'b1, 1'b1); cycle();
        both_q("R2 clear over load");
        chk("R2 clear value", 32'(q_a), 32'h0);
    endtask

    task automatic t_async();
        din = 8'h37; set(1'b1, 1'b0, 1'b0, 1'b0); cycle();
        set(1'b1, 1'b1, 1'b0, 1'b0);
        clear_n = 1'b0; #1;
        chk("R3 async clear mid-cycle", 32'(q_a), 32'h0);
        chk("R4 sync waits for edge", 32'(q_s), 32'h37);
        cycle();
        chk("R4 sync clears at edge", 32'(q_s), 32'h0);
        both_q("R4 after clear edge");
        clear_n = 1'b1; cycle();
    endtask

    initial begin
        t_reset();
        t_load();
        t_count();
        t_hold();
        t_wrap();
        t_carry();
        t_prec();
        t_async();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule